// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects 39 external interrupt lines plus a cascaded group of 32 secondary sources and presents them to a processor as a single interrupt request. Each of the 40 primary channels takes its input from a source line chosen by a writable per-channel map entry. The channel number is the priority: channel 0 is the highest. Source line 0 is not a pin. It carries the summary of the secondary group, so the secondary group reaches the processor through whichever channel maps line 0. After reset that is channel 0.

Each channel has a polarity bit and a trigger-type bit. A level channel mirrors its qualified input. An edge channel latches on the active edge and keeps the request until software clears it. Software arms and disarms channels through write-one set and clear registers. It reads a priority index that names the winning channel, and it can write a mask index that hides every channel at or above a chosen number. Register accesses are single-cycle: writes take effect at the clock edge, and read data is combinational from the address.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all enables and pending bits are zero. The mask index reads 40, the priority index reads 40, polarity reads all zero, type reads all ones (level), every map entry N reads N, and irqOut is low.
- R2: A level channel (type bit 1) shows its qualified input in its status bit one clock after the input changes. Status words are read at 0x00 + 4*bank, where channel c is bit c%32 of bank c/32.
- R3: An edge channel (type bit 0) sets its status bit on the rising edge of its qualified input and holds it until a 1 is written to that bit at 0x10 + 4*bank. A new edge in the same cycle as the clear wins.
- R4: A polarity bit of 1 (written at 0x50 + 4*bank) inverts the channel input, so the channel becomes active-low.
- R5: Writing 1s at 0x20 + 4*bank sets enable bits, and writing 1s at 0x30 + 4*bank clears them. Zero bits have no effect. Both addresses read back the enable word. Bank 1 holds only bits 7:0.
- R6: The word at 0x40 returns in bits 21:16 the lowest-numbered channel that is pending, enabled and unmasked, or 40 when there is none.
- R7: The mask index at 0x44 (bits 5:0) makes every channel whose number is at or above it ineligible. 40 lets all channels through.
- R8: Map entry N at 0x200 + 4*N (bits 5:0) selects the source line that drives channel N. Line L ≥ 1 is srcLines bit L-1.
- R9: Each secondary source latches a rising edge into a status bit read at 0x80. Writing 1s at 0x88 clears status bits. Writing 1s at 0x90 and 0x98 sets and clears secondary enables, and both addresses read back the enables. Source line 0 is high while any enabled secondary bit is pending.
- R10: irqOut is high exactly when some primary channel is eligible or some enabled secondary bit is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Register access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address, word aligned |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| srcLines | input | 39 | Source lines 1 to 39 (bit k is line k+1) |
| secLines | input | 32 | Secondary sources |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is the cascade. A secondary pulse first has to set its latched status bit. The enabled summary then feeds line 0, and only one cycle later does channel 0's level status rise and win the index. The bench pulses one enabled secondary input and reads the priority index only after two edges. It checks that irqOut rises one edge earlier, even while channel 0 is still disabled. Remapping channel 3 to line 30 also shows that the map and not the line number sets the priority: the channel 3 status bit and the index follow line 30.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int PRIM_CHANS = 40;
  localparam int SEC_SRCS   = 32;
  localparam int WORD_W     = 32;
  localparam int BANKS      = (PRIM_CHANS + WORD_W - 1) / WORD_W;
  localparam int CHAN_W     = $clog2(PRIM_CHANS + 1);
  localparam int MAP_IW     = $clog2(PRIM_CHANS);

  typedef enum logic [3:0] {
    RD_NONE, RD_STATUS, RD_ENABLE, RD_INDEX, RD_MASK,
    RD_POL, RD_TYPE, RD_SECSTAT, RD_SECEN, RD_MAP
  } rdsel_e;

  typedef struct packed {
    logic [BANKS-1:0] statClr;
    logic [BANKS-1:0] enSet;
    logic [BANKS-1:0] enClr;
    logic [BANKS-1:0] polWr;
    logic [BANKS-1:0] typWr;
    logic             maskWr;
    logic             mapWr;
    logic             secClr;
    logic             secEnSet;
    logic             secEnClr;
    logic [1:0]       bank;
    logic [6:0]       mapIdx;
    rdsel_e           rdSel;
  } strobe_t;
endpackage

// File: rtl/prio_irq_decode.sv
module prio_irq_decode
  import prio_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           st
);
  logic wrHit, rdHit;
  logic [ADDR_W-7:0] upperA;
  logic [1:0] grp, bk;
  logic [BANKS-1:0] bankHot;
  logic mapOk;

  always_comb begin
    wrHit  = busSel && (busAddr[1:0] == 2'b00) && busWr;
    rdHit  = busSel && (busAddr[1:0] == 2'b00) && !busWr;
    upperA = busAddr[ADDR_W-1:6];
    grp    = busAddr[5:4];
    bk     = busAddr[3:2];
    for (int b = 0; b < BANKS; b++) bankHot[b] = (int'(bk) == b);
    mapOk  = (busAddr[ADDR_W-1:9] == 1) && (int'(busAddr[8:2]) < PRIM_CHANS);

    st        = '0;
    st.rdSel  = RD_NONE;
    st.bank   = bk;
    st.mapIdx = busAddr[8:2];

    if (upperA == 0) begin
      unique case (grp)
        2'd0: if (rdHit) st.rdSel = RD_STATUS;
        2'd1: if (wrHit) st.statClr = bankHot;
        2'd2: begin
          if (wrHit) st.enSet = bankHot;
          if (rdHit) st.rdSel = RD_ENABLE;
        end
        default: begin
          if (wrHit) st.enClr = bankHot;
          if (rdHit) st.rdSel = RD_ENABLE;
        end
      endcase
    end else if (upperA == 1) begin
      if (grp == 2'd0 && bk == 2'd0) begin
        if (rdHit) st.rdSel = RD_INDEX;
      end else if (grp == 2'd0 && bk == 2'd1) begin
        st.maskWr = wrHit;
        if (rdHit) st.rdSel = RD_MASK;
      end else if (grp == 2'd1) begin
        if (wrHit) st.polWr = bankHot;
        if (rdHit) st.rdSel = RD_POL;
      end else if (grp == 2'd2) begin
        if (wrHit) st.typWr = bankHot;
        if (rdHit) st.rdSel = RD_TYPE;
      end
    end else if (upperA == 2 && busAddr[5] == 1'b0 && busAddr[2] == 1'b0) begin
      unique case (busAddr[4:3])
        2'd0: if (rdHit) st.rdSel = RD_SECSTAT;
        2'd1: st.secClr = wrHit;
        2'd2: begin
          st.secEnSet = wrHit;
          if (rdHit) st.rdSel = RD_SECEN;
        end
        default: begin
          st.secEnClr = wrHit;
          if (rdHit) st.rdSel = RD_SECEN;
        end
      endcase
    end else if (mapOk) begin
      st.mapWr = wrHit;
      if (rdHit) st.rdSel = RD_MAP;
    end
  end
endmodule

// File: rtl/prio_irq_datapath.sv
module prio_irq_datapath
  import prio_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               st,
  input  logic [WORD_W-1:0]     busWdata,
  input  logic [PRIM_CHANS-2:0] srcLines,
  input  logic [SEC_SRCS-1:0]   secLines,
  output logic [WORD_W-1:0]     busRdata,
  output logic                  irqOut,
  output logic [CHAN_W-1:0]     winIdx,
  output logic [CHAN_W-1:0]     maskIdx,
  output logic [PRIM_CHANS-1:0] enableVec,
  output logic [SEC_SRCS-1:0]   secPend
);
  localparam int PAD_W = BANKS * WORD_W;

  logic [PRIM_CHANS-1:0] enableQ, polQ, typQ, statusQ, qPrev, qual, elig;
  logic [CHAN_W-1:0]     chanMap [PRIM_CHANS];
  logic [CHAN_W-1:0]     maskQ;
  logic [SEC_SRCS-1:0]   secStatus, secEn, secPrev;
  logic [PRIM_CHANS-1:0] lineVec;
  logic                  secAny;

  assign secAny  = |(secStatus & secEn);
  assign lineVec = {srcLines, secAny};

  genvar gc;
  generate
    for (gc = 0; gc < PRIM_CHANS; gc++) begin : g_chan
      localparam int BK = gc / WORD_W;
      localparam int BT = gc % WORD_W;
      logic srcSel, rise, clrHit;
      assign srcSel = (int'(chanMap[gc]) < PRIM_CHANS) ? lineVec[chanMap[gc][MAP_IW-1:0]] : 1'b0;
      assign qual[gc] = srcSel ^ polQ[gc];
      assign rise     = qual[gc] & ~qPrev[gc];
      assign clrHit   = st.statClr[BK] & busWdata[BT];
      assign elig[gc] = statusQ[gc] & enableQ[gc] & (CHAN_W'(gc) < maskQ);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          enableQ[gc] <= 1'b0;
          polQ[gc]    <= 1'b0;
          typQ[gc]    <= 1'b1;
          statusQ[gc] <= 1'b0;
          qPrev[gc]   <= 1'b0;
          chanMap[gc] <= CHAN_W'(gc);
        end else begin
          qPrev[gc] <= qual[gc];
          if (st.enSet[BK] && busWdata[BT]) enableQ[gc] <= 1'b1;
          else if (st.enClr[BK] && busWdata[BT]) enableQ[gc] <= 1'b0;
          if (st.polWr[BK]) polQ[gc] <= busWdata[BT];
          if (st.typWr[BK]) typQ[gc] <= busWdata[BT];
          if (st.mapWr && int'(st.mapIdx) == gc) chanMap[gc] <= busWdata[CHAN_W-1:0];
          if (typQ[gc]) statusQ[gc] <= qual[gc];
          else          statusQ[gc] <= rise | (statusQ[gc] & ~clrHit);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ     <= CHAN_W'(PRIM_CHANS);
      secStatus <= '0;
      secEn     <= '0;
      secPrev   <= '0;
    end else begin
      secPrev <= secLines;
      if (st.maskWr) maskQ <= busWdata[CHAN_W-1:0];
      secStatus <= (secLines & ~secPrev) |
                   (secStatus & ~(st.secClr ? busWdata[SEC_SRCS-1:0] : '0));
      if (st.secEnSet)      secEn <= secEn | busWdata[SEC_SRCS-1:0];
      else if (st.secEnClr) secEn <= secEn & ~busWdata[SEC_SRCS-1:0];
    end
  end

  // lowest-numbered eligible channel wins
  always_comb begin
    winIdx = CHAN_W'(PRIM_CHANS);
    for (int i = PRIM_CHANS - 1; i >= 0; i--)
      if (elig[i]) winIdx = CHAN_W'(i);
  end

  assign irqOut    = (|elig) | secAny;
  assign maskIdx   = maskQ;
  assign enableVec = enableQ;
  assign secPend   = secStatus;

  logic [PAD_W-1:0] padSrc;
  logic             bankOk;

  always_comb begin
    bankOk = int'(st.bank) < BANKS;
    padSrc = '0;
    unique case (st.rdSel)
      RD_STATUS: padSrc[PRIM_CHANS-1:0] = statusQ;
      RD_ENABLE: padSrc[PRIM_CHANS-1:0] = enableQ;
      RD_POL:    padSrc[PRIM_CHANS-1:0] = polQ;
      RD_TYPE:   padSrc[PRIM_CHANS-1:0] = typQ;
      default:   padSrc = '0;
    endcase
    busRdata = '0;
    unique case (st.rdSel)
      RD_STATUS, RD_ENABLE, RD_POL, RD_TYPE:
        if (bankOk) busRdata = padSrc[int'(st.bank)*WORD_W +: WORD_W];
      RD_INDEX:   busRdata[16 +: CHAN_W] = winIdx;
      RD_MASK:    busRdata[CHAN_W-1:0] = maskQ;
      RD_SECSTAT: busRdata[SEC_SRCS-1:0] = secStatus;
      RD_SECEN:   busRdata[SEC_SRCS-1:0] = secEn;
      RD_MAP:     busRdata[CHAN_W-1:0] = chanMap[st.mapIdx[MAP_IW-1:0]];
      default:    busRdata = '0;
    endcase
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWr,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [WORD_W-1:0]     busWdata,
  output logic [WORD_W-1:0]     busRdata,
  input  logic [PRIM_CHANS-2:0] srcLines,
  input  logic [SEC_SRCS-1:0]   secLines,
  output logic                  irqOut
);
  strobe_t               strobes;
  logic [CHAN_W-1:0]     winIdx, maskIdx;
  logic [PRIM_CHANS-1:0] enableVec;
  logic [SEC_SRCS-1:0]   secPend;

  prio_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .st     (strobes)
  );

  prio_irq_datapath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .st       (strobes),
    .busWdata (busWdata),
    .srcLines (srcLines),
    .secLines (secLines),
    .busRdata (busRdata),
    .irqOut   (irqOut),
    .winIdx   (winIdx),
    .maskIdx  (maskIdx),
    .enableVec(enableVec),
    .secPend  (secPend)
  );
endmodule

// File: rtl/prio_irq_checker.sv
module prio_irq_checker
  import prio_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busSel,
  input logic                  busWr,
  input logic [ADDR_W-1:0]     busAddr,
  input logic [WORD_W-1:0]     busWdata,
  input logic [SEC_SRCS-1:0]   secLines,
  input logic                  irqOut,
  input logic [CHAN_W-1:0]     winIdx,
  input logic [CHAN_W-1:0]     maskIdx,
  input logic [PRIM_CHANS-1:0] enableVec,
  input logic [SEC_SRCS-1:0]   secPend
);
  assert_mask_respected_R7: assert property (@(posedge clk) disable iff (!rstN)
    (winIdx == CHAN_W'(PRIM_CHANS)) || (winIdx < maskIdx));

  assert_quiet_no_winner_R10: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> (winIdx == CHAN_W'(PRIM_CHANS)));

  assert_winner_enabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    (winIdx != CHAN_W'(PRIM_CHANS)) |-> enableVec[winIdx[MAP_IW-1:0]]);

  assert_enable_set_sticks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == ADDR_W'(12'h020)) |=>
      ((enableVec[WORD_W-1:0] & $past(busWdata)) == $past(busWdata)));

  assert_sec_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == ADDR_W'(12'h088)) |=>
      ((secPend & $past(busWdata) & ~$past(secLines)) == '0));
endmodule

bind prio_irq_ctrl prio_irq_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .secLines(secLines), .irqOut(irqOut), .winIdx(winIdx),
  .maskIdx(maskIdx), .enableVec(enableVec), .secPend(secPend)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [38:0] srcLines = '0;
  logic [31:0] secLines = '0;
  logic        irqOut;
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .srcLines(srcLines),
    .secLines(secLines), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic setLine(input int n, input logic v);
    srcLines[n-1] = v;
  endtask

  function automatic logic [31:0] idxWord(input int c);
    return 32'(c) << 16;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h040, d); check("R1 index", d, idxWord(40));
    rd(12'h044, d); check("R1 mask", d, 32'd40);
    rd(12'h214, d); check("R1 map5", d, 32'd5);
    rd(12'h060, d); check("R1 type bank0", d, 32'hFFFF_FFFF);
    rd(12'h064, d); check("R1 type bank1", d, 32'h0000_00FF);
    rd(12'h050, d); check("R1 pol bank0", d, 32'h0);
    rd(12'h020, d); check("R1 enable bank0", d, 32'h0);
    check("R1 irqOut", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(12'h020, 32'h20);
    setLine(5, 1'b1); tick();
    rd(12'h000, d); check("R2 level status high", d, 32'h20);
    rd(12'h040, d); check("R6 index level", d, idxWord(5));
    check("R10 irq on level", {31'b0, irqOut}, 32'h1);
    setLine(5, 1'b0); tick();
    rd(12'h000, d); check("R2 level status follows low", d, 32'h0);
    rd(12'h040, d); check("R6 index idle", d, idxWord(40));
    check("R10 irq off", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    wr(12'h020, 32'h1000);
    setLine(5, 1'b1); setLine(12, 1'b1); tick();
    rd(12'h040, d); check("R6 lower channel wins", d, idxWord(5));
    wr(12'h030, 32'h20);
    rd(12'h020, d); check("R5 enable after clear", d, 32'h1000);
    rd(12'h040, d); check("R6 next channel wins", d, idxWord(12));
    wr(12'h024, 32'hFFFF_FFFF);
    rd(12'h024, d); check("R5 bank1 only 8 bits", d, 32'hFF);
    wr(12'h034, 32'hFFFF_FFFF);
    rd(12'h034, d); check("R5 bank1 cleared", d, 32'h0);
    setLine(5, 1'b0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(12'h044, 32'd12);
    rd(12'h040, d); check("R7 masked at index", d, idxWord(40));
    check("R7 irq masked", {31'b0, irqOut}, 32'h0);
    wr(12'h044, 32'd13);
    rd(12'h040, d); check("R7 above mask passes", d, idxWord(12));
    wr(12'h044, 32'd40);
    setLine(12, 1'b0);
    wr(12'h030, 32'h1000);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(12'h060, 32'hFFEF_FFFF);
    wr(12'h020, 32'h0010_0000);
    tick();
    setLine(20, 1'b1); tick();
    setLine(20, 1'b0); tick();
    rd(12'h000, d); check("R3 edge latched", d, 32'h0010_0000);
    repeat (3) tick();
    rd(12'h000, d); check("R3 edge held", d, 32'h0010_0000);
    rd(12'h040, d); check("R3 index edge", d, idxWord(20));
    wr(12'h010, 32'h0000_0001);
    tick();
    rd(12'h000, d); check("R3 other-bit clear ignored", d, 32'h0010_0000);
    wr(12'h010, 32'h0010_0000);
    rd(12'h000, d); check("R3 edge cleared", d, 32'h0);
    wr(12'h030, 32'h0010_0000);
    wr(12'h060, 32'hFFFF_FFFF);
  endtask

  task automatic t_polarity();
    logic [31:0] d;
    wr(12'h054, 32'h2);
    tick();
    rd(12'h004, d); check("R4 active-low pending", d, 32'h2);
    wr(12'h024, 32'h2);
    rd(12'h040, d); check("R4 index ch33", d, idxWord(33));
    setLine(33, 1'b1); tick();
    rd(12'h004, d); check("R4 high is inactive", d, 32'h0);
    setLine(33, 1'b0);
    wr(12'h034, 32'h2);
    wr(12'h054, 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(12'h20C, 32'd30);
    rd(12'h20C, d); check("R8 map readback", d, 32'd30);
    wr(12'h020, 32'h8);
    setLine(30, 1'b1); tick();
    rd(12'h000, d); check("R8 ch3 follows line30", d, 32'h4000_0008);
    rd(12'h040, d); check("R8 index remapped", d, idxWord(3));
    setLine(30, 1'b0);
    setLine(3, 1'b1); tick();
    rd(12'h000, d); check("R8 line3 no longer drives ch3", d, 32'h0);
    setLine(3, 1'b0);
    wr(12'h030, 32'h8);
    wr(12'h20C, 32'd3);
  endtask

  task automatic t_secondary();
    logic [31:0] d;
    wr(12'h090, 32'h80);
    rd(12'h090, d); check("R9 sec enable readback", d, 32'h80);
    secLines[7] = 1'b1; tick();
    secLines[7] = 1'b0; tick();
    rd(12'h080, d); check("R9 sec status latched", d, 32'h80);
    check("R10 irq from secondary", {31'b0, irqOut}, 32'h1);
    rd(12'h040, d); check("R6 ch0 disabled no winner", d, idxWord(40));
    wr(12'h020, 32'h1);
    rd(12'h040, d); check("R9 cascade index 0", d, idxWord(0));
    wr(12'h088, 32'h80);
    tick();
    rd(12'h080, d); check("R9 sec cleared", d, 32'h0);
    rd(12'h040, d); check("R9 cascade idle", d, idxWord(40));
    check("R10 irq clear", {31'b0, irqOut}, 32'h0);
    secLines[3] = 1'b1; tick();
    secLines[3] = 1'b0; tick();
    rd(12'h080, d); check("R9 disabled src latches", d, 32'h8);
    check("R9 disabled src no irq", {31'b0, irqOut}, 32'h0);
    wr(12'h088, 32'h8);
    wr(12'h098, 32'h80);
    rd(12'h098, d); check("R9 sec enable cleared", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    t_reset();
    t_level();
    t_priority();
    t_mask();
    t_edge();
    t_polarity();
    t_map();
    t_secondary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule